// File: doc/BRIEF.md
# Byte-Wide Timer Bus Interface

This block sits between an 8-bit host port and three 16-bit countdown channels. A 2-bit address selects one of three channel data ports (addresses 0, 1, 2) or the control-word port (address 3). Control words set a channel's mode, its BCD flag and its byte-access scheme. They can also take a snapshot of a channel's running count. Data-port writes assemble 16-bit reload values from one or two bytes and hand them to the channel with a one-cycle load strobe. Data-port reads return bytes of either the live count or a frozen snapshot.

The counters themselves are outside the block. Each channel's present count enters on `live_cnt`. Each channel's mode, BCD flag, reload value, load strobe and half-written flag leave on the packed output buses, with channel n in slice n.

The host port is a plain strobe interface and never back-pressures. Every strobe is taken in the cycle it is seen. Read data is registered and valid in the cycle after `rd_en`, and it holds until the next read. `wr_en` and `rd_en` may be high in the same cycle. Both then act on the same address.

Top module: `tmr_host_port`

## Requirements
- R1: After reset every channel has mode 0, BCD 0, reload value 0, no load strobe and no half-written flag, and `rd_data` is 0. Every channel's access scheme starts as low-byte-then-high-byte.
- R2: A write at address 3 carries the channel select in bits 7:6 (00, 01, 10 pick channels 0, 1, 2), the access scheme in bits 5:4, the mode in bits 3:1 and BCD in bit 0. When the access field is nonzero, the selected channel takes the new mode, BCD flag and scheme on the next cycle. No other channel changes.
- R3: A control word whose select field is 11 changes nothing.
- R4: With scheme 10 (low byte only), a data write of byte d gives reload value {8'h00, d} with a one-cycle load strobe in the next cycle.
- R5: With scheme 01 (high byte only), a data write of byte d gives reload value {d, 8'h00} with a load strobe.
- R6: With scheme 11, the first data write only stores the byte and raises the half-written flag. The second write produces {second, first} with a load strobe and clears the flag.
- R7: A mode-setting control word restarts its channel. It clears the write and read byte toggles, the half-written flag and any pending snapshot.
- R8: Read data appears one cycle after `rd_en`. Scheme 10 returns the low byte and scheme 01 the high byte. Scheme 11 returns low, then high, alternating, and starts with low after a control word.
- R9: A control word with access field 00 copies the channel's live count into a snapshot. Reads return the snapshot until it has been fully read: one read for schemes 01 and 10, or the high-byte read for scheme 11. The command leaves the mode, BCD flag and scheme unchanged.
- R10: A snapshot command for a channel whose snapshot is still unread is ignored.
- R11: A read at address 3 returns 8'h00.
- R12: A data-port write and read in the same cycle act independently. The read sees the byte toggle and the count as they were before that cycle, and the write's byte toggle advances separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0..2 channel data, 3 control word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write byte |
| live_cnt | input | 48 | Present count of each channel, channel n in bits 16n+15:16n |
| rd_data | output | 8 | Registered read byte |
| ch_mode | output | 9 | Mode of each channel, 3 bits per channel |
| ch_bcd | output | 3 | BCD flag of each channel |
| ch_load_val | output | 48 | Reload value of each channel |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_half | output | 3 | Half-written flag per channel |

## Verification
The two functions that can meet in one cycle are a data-port write and a data-port read of the same channel in scheme 11. Each advances its own byte toggle. The read must return the byte picked by the read toggle before the cycle, while the write either stores a low byte or completes a load. The bench provokes this directly and also through random traffic in which both strobes are often high together. A reference model applies the read effects to the pre-cycle state and then applies the write. Its expected read byte, load strobe and half-written flag are compared in the cycle after.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Byte-access scheme carried in control-word bits 5:4
  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_HI   = 2'b01,
    ACC_LO   = 2'b10,
    ACC_PAIR = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0] sel;
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } ctl_word_t;

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wr_data,
  output logic [NCH-1:0] cw_set,
  output logic [NCH-1:0] cw_snap,
  output logic [NCH-1:0] dat_we,
  output logic [NCH-1:0] dat_re,
  output logic [2:0]    f_mode,
  output logic          f_bcd,
  output acc_e          f_acc
);
  localparam logic [1:0] CTL_ADDR = 2'd3;

  ctl_word_t cw;
  logic      is_ctl;

  assign cw     = ctl_word_t'(wr_data[7:0]);
  assign is_ctl = wr_en && (addr == CTL_ADDR);
  assign f_mode = cw.mode;
  assign f_bcd  = cw.bcd;
  assign f_acc  = cw.acc;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit        = is_ctl && (cw.sel == 2'(i));
    assign cw_set[i]  = hit && (cw.acc != ACC_SNAP);
    assign cw_snap[i] = hit && (cw.acc == ACC_SNAP);
    assign dat_we[i]  = wr_en && (addr == 2'(i));
    assign dat_re[i]  = rd_en && (addr == 2'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cw_set,
  input  logic            cw_snap,
  input  logic [2:0]      f_mode,
  input  logic            f_bcd,
  input  acc_e            f_acc,
  input  logic            dat_we,
  input  logic            dat_re,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] live,
  output logic [2:0]      mode,
  output logic            bcd,
  output logic [2*DW-1:0] load_val,
  output logic            load,
  output logic            half,
  output logic [DW-1:0]   rd_byte
);
  localparam int CW = 2 * DW;

  acc_e          acc;
  logic          wtgl;
  logic          rtgl;
  logic          snapped;
  logic [DW-1:0] stage;
  logic [CW-1:0] hold;
  logic [CW-1:0] src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= '0;
      bcd      <= 1'b0;
      acc      <= ACC_PAIR;
      wtgl     <= 1'b0;
      rtgl     <= 1'b0;
      snapped  <= 1'b0;
      stage    <= '0;
      hold     <= '0;
      load_val <= '0;
      load     <= 1'b0;
      half     <= 1'b0;
    end else begin
      load <= 1'b0;
      if (cw_set) begin
        mode    <= f_mode;
        bcd     <= f_bcd;
        acc     <= f_acc;
        wtgl    <= 1'b0;
        rtgl    <= 1'b0;
        snapped <= 1'b0;
        half    <= 1'b0;
      end else begin
        if (cw_snap && !snapped) begin
          snapped <= 1'b1;
          hold    <= live;
        end
        if (dat_re) begin
          if (acc == ACC_PAIR) rtgl <= ~rtgl;
          if (snapped && (acc != ACC_PAIR || rtgl)) snapped <= 1'b0;
        end
        if (dat_we) begin
          unique case (acc)
            ACC_LO: begin
              load_val <= {{DW{1'b0}}, wdata};
              load     <= 1'b1;
            end
            ACC_HI: begin
              load_val <= {wdata, {DW{1'b0}}};
              load     <= 1'b1;
            end
            default: begin
              if (!wtgl) begin
                stage <= wdata;
                wtgl  <= 1'b1;
                half  <= 1'b1;
              end else begin
                load_val <= {wdata, stage};
                load     <= 1'b1;
                wtgl     <= 1'b0;
                half     <= 1'b0;
              end
            end
          endcase
        end
      end
    end
  end

  assign src = snapped ? hold : live;

  always_comb begin
    unique case (acc)
      ACC_HI:   rd_byte = src[CW-1:DW];
      ACC_PAIR: rd_byte = rtgl ? src[CW-1:DW] : src[DW-1:0];
      default:  rd_byte = src[DW-1:0];
    endcase
  end
endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
  import tmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [3*2*DW-1:0] live_cnt,
  output logic [DW-1:0]     rd_data,
  output logic [3*3-1:0]    ch_mode,
  output logic [2:0]        ch_bcd,
  output logic [3*2*DW-1:0] ch_load_val,
  output logic [2:0]        ch_load,
  output logic [2:0]        ch_half
);
  localparam int NCH = 3;
  localparam int CW  = 2 * DW;

  logic [NCH-1:0] cw_set, cw_snap, dat_we, dat_re;
  logic [2:0]     f_mode;
  logic           f_bcd;
  acc_e           f_acc;
  logic [DW-1:0]  rdb [NCH];
  logic [DW-1:0]  rd_next;

  tmr_cw_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .cw_set(cw_set), .cw_snap(cw_snap), .dat_we(dat_we), .dat_re(dat_re),
    .f_mode(f_mode), .f_bcd(f_bcd), .f_acc(f_acc)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_regs #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cw_set(cw_set[i]), .cw_snap(cw_snap[i]),
      .f_mode(f_mode), .f_bcd(f_bcd), .f_acc(f_acc),
      .dat_we(dat_we[i]), .dat_re(dat_re[i]), .wdata(wr_data),
      .live(live_cnt[i*CW +: CW]),
      .mode(ch_mode[i*3 +: 3]), .bcd(ch_bcd[i]),
      .load_val(ch_load_val[i*CW +: CW]), .load(ch_load[i]),
      .half(ch_half[i]), .rd_byte(rdb[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) rd_next = rdb[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/tmr_host_port_chk.sv
module tmr_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic [8:0]  ch_mode,
  input logic [2:0]  ch_bcd,
  input logic [2:0]  ch_load,
  input logic [2:0]  ch_half
);
  // R3: select 11 leaves every mode and BCD flag alone
  a_r3_sel3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wr_data[7:6] == 2'b11) |=> ($stable(ch_mode) && $stable(ch_bcd)));

  // R2: mode and BCD change only through the control port
  a_r2_mode_by_ctl_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 2'd3) |=> ($stable(ch_mode) && $stable(ch_bcd)));

  // R8: read data holds between reads
  a_r8_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R11: reads of the control port return zero
  a_r11_ctl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rd_data == 8'h00));

  for (genvar i = 0; i < 3; i++) begin : g_c
    // R4: a load strobe follows a write to that channel's data port
    a_r4_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> $past(wr_en && addr == 2'(i)));
    // R6: completing a pair never leaves the half flag up
    a_r6_load_clears_half: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> !ch_half[i]);
    // R6: the half flag rises only after a data write to that channel
    a_r6_half_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_half[i]) |-> $past(wr_en && addr == 2'(i)));
  end
endmodule

bind tmr_host_port tmr_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_data(wr_data), .rd_data(rd_data), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
  .ch_load(ch_load), .ch_half(ch_half)
);

// File: tb/tmr_host_port_bench.sv
module tmr_host_port_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [47:0] live_cnt = '0;
  logic [7:0]  rd_data;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_load, ch_half;
  logic [47:0] ch_load_val;

  always #(CLK_NS/2) clk = ~clk;

  tmr_host_port u_tmr_host_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .live_cnt(live_cnt), .rd_data(rd_data),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load_val(ch_load_val),
    .ch_load(ch_load), .ch_half(ch_half)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0]  m_mode [3];
  logic        m_bcd  [3];
  logic [1:0]  m_acc  [3];
  logic        m_wt [3], m_rt [3], m_snap [3], m_half [3];
  logic [7:0]  m_stage [3];
  logic [15:0] m_hold [3], m_lv [3];
  logic [7:0]  m_rd;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_mode();
    return {m_mode[2], m_mode[1], m_mode[0]};
  endfunction

  function automatic logic [2:0] exp_half();
    return {m_half[2], m_half[1], m_half[0]};
  endfunction

  task automatic op(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d,
                    input string tag);
    logic [15:0] src;
    logic [2:0]  eld;
    int c;
    eld = '0;
    @(negedge clk);
    live_cnt = {16'($urandom), 16'($urandom), 16'($urandom)};
    addr = a; wr_en = w; rd_en = r; wr_data = d;
    // read effects on the pre-cycle state (R12)
    if (r) begin
      if (a == 2'd3) m_rd = 8'h00;
      else begin
        c = int'(a);
        src = m_snap[c] ? m_hold[c] : live_cnt[c*16 +: 16];
        case (m_acc[c])
          2'b01: begin m_rd = src[15:8]; m_snap[c] = 1'b0; end
          2'b10: begin m_rd = src[7:0];  m_snap[c] = 1'b0; end
          default: begin
            m_rd = m_rt[c] ? src[15:8] : src[7:0];
            if (m_rt[c]) m_snap[c] = 1'b0;
            m_rt[c] = ~m_rt[c];
          end
        endcase
      end
    end
    if (w && a == 2'd3) begin
      c = int'(d[7:6]);
      if (c != 3) begin
        if (d[5:4] == 2'b00) begin
          if (!m_snap[c]) begin m_snap[c] = 1'b1; m_hold[c] = live_cnt[c*16 +: 16]; end
        end else begin
          m_mode[c] = d[3:1]; m_bcd[c] = d[0]; m_acc[c] = d[5:4];
          m_wt[c] = 1'b0; m_rt[c] = 1'b0; m_snap[c] = 1'b0; m_half[c] = 1'b0;
        end
      end
    end else if (w) begin
      c = int'(a);
      case (m_acc[c])
        2'b10: begin m_lv[c] = {8'h00, d}; eld[c] = 1'b1; end
        2'b01: begin m_lv[c] = {d, 8'h00}; eld[c] = 1'b1; end
        default: begin
          if (!m_wt[c]) begin m_stage[c] = d; m_wt[c] = 1'b1; m_half[c] = 1'b1; end
          else begin
            m_lv[c] = {d, m_stage[c]}; eld[c] = 1'b1; m_wt[c] = 1'b0; m_half[c] = 1'b0;
          end
        end
      endcase
    end
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    if (r) chk(rd_data == m_rd, {tag, " R8 read byte"}, rd_data, m_rd);
    chk(ch_load == eld, {tag, " R4 load strobe"}, ch_load, eld);
    for (int k = 0; k < 3; k++)
      if (eld[k]) chk(ch_load_val[k*16 +: 16] == m_lv[k], {tag, " R6 reload value"},
                      ch_load_val[k*16 +: 16], m_lv[k]);
    chk(ch_half == exp_half(), {tag, " R6 half flag"}, ch_half, exp_half());
    chk(ch_mode == exp_mode() && ch_bcd == {m_bcd[2], m_bcd[1], m_bcd[0]},
        {tag, " R2 mode/bcd"}, {ch_mode, ch_bcd}, {exp_mode(), m_bcd[2], m_bcd[1], m_bcd[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    for (int k = 0; k < 3; k++) begin
      m_mode[k] = '0; m_bcd[k] = 1'b0; m_acc[k] = 2'b11; m_wt[k] = 1'b0; m_rt[k] = 1'b0;
      m_snap[k] = 1'b0; m_half[k] = 1'b0; m_stage[k] = '0; m_hold[k] = '0; m_lv[k] = '0;
    end
    m_rd = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(ch_mode == '0 && ch_bcd == '0, "R1 mode/bcd", {ch_mode, ch_bcd}, 0);
    chk(ch_load == '0 && ch_half == '0, "R1 strobes", {ch_load, ch_half}, 0);
    chk(ch_load_val == '0 && rd_data == '0, "R1 values", {ch_load_val[39:0], rd_data}, 0);

    // R2 / R4: channel 0, low byte only, mode 2, BCD
    op(1, 0, 2'd3, 8'h25, "R2 ctl ch0");
    op(1, 0, 2'd0, 8'h5A, "R4 lo write");
    // R5: channel 1, high byte only, mode 3
    op(1, 0, 2'd3, 8'h56, "R2 ctl ch1");
    op(1, 0, 2'd1, 8'hC3, "R5 hi write");
    // R6: channel 2, pair, mode 4
    op(1, 0, 2'd3, 8'hB8, "R2 ctl ch2");
    op(1, 0, 2'd2, 8'h34, "R6 first byte");
    op(1, 0, 2'd2, 8'h12, "R6 second byte");
    // R7: restart mid-pair clears the half flag
    op(1, 0, 2'd2, 8'h77, "R7 half pending");
    op(1, 0, 2'd3, 8'hB8, "R7 restart");
    op(1, 0, 2'd2, 8'h11, "R7 fresh first byte");
    op(1, 0, 2'd2, 8'h22, "R7 completes");
    // R3: select 11 ignored
    op(1, 0, 2'd3, 8'hFF, "R3 sel 11");
    op(1, 0, 2'd3, 8'hC0, "R3 sel 11 snapshot");
    // R8: reads in each scheme
    op(0, 1, 2'd0, 8'h00, "R8 lo read");
    op(0, 1, 2'd1, 8'h00, "R8 hi read");
    op(0, 1, 2'd2, 8'h00, "R8 pair low");
    op(0, 1, 2'd2, 8'h00, "R8 pair high");
    // R9 / R10: snapshot, second command ignored, reads return first capture
    op(1, 0, 2'd3, 8'h80, "R9 snapshot ch2");
    op(1, 0, 2'd3, 8'h80, "R10 repeat ignored");
    op(0, 1, 2'd2, 8'h00, "R9 snap low");
    op(0, 1, 2'd2, 8'h00, "R9 snap high");
    op(0, 1, 2'd2, 8'h00, "R9 live again");
    op(1, 0, 2'd3, 8'h00, "R9 snapshot ch0");
    op(0, 1, 2'd0, 8'h00, "R9 snap lo-only");
    op(0, 1, 2'd0, 8'h00, "R9 released");
    // R11
    op(0, 1, 2'd3, 8'h00, "R11 ctl read");
    // R12: write and read together on a pair-scheme port
    op(1, 0, 2'd3, 8'hB8, "R12 setup");
    op(1, 1, 2'd2, 8'hA1, "R12 both first");
    op(1, 1, 2'd2, 8'hB2, "R12 both second");
    op(0, 1, 2'd2, 8'h00, "R12 read low");

    for (int n = 0; n < 400; n++) begin
      logic [1:0] ra;
      ra = 2'($urandom);
      op(1'($urandom), ($urandom % 3) == 0, ra, 8'($urandom), "rnd");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule